// File: doc/BRIEF.md
# IDE Port Memory-Mapped Strobe Decoder

This block sits between a 16-bit processor's memory bus and an IDE drive port that is mapped into memory. It watches the word address, the memory-enable strobe, the read qualifier and the write enable. When an access falls inside the configured 1 KB window, it produces the drive chip select, the read strobe and the write strobe, all active low. The base of the window comes from two one-hot selectors. The first picks one of eight 8 KB regions. The second picks one of eight 1 KB windows inside that region.

Reads and writes reach the drive through different address aliases, chosen by a split bit in the word address. A processor that reads a location before writing it therefore never issues a drive read at a write alias. Both strobes only assert while the chip select is active. The read strobe is held back a parameterised number of clocks, so its falling edge always comes after the chip select. The low word-address bits pass straight through as the drive register select. An activity input from the drive is inverted onto an indicator output.

The bus is modelled synchronously: the address and qualifiers are sampled on each rising clock edge. The port has no data stream, so every pin is a plain level control.

Top module: `ide_port_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, cs0_no, read_no and write_no are all 1.
- R2: Word address bits 14:12 form the region index and bits 11:9 the window index (the byte address is twice the word address). An access is a hit when memen_ni is 0, region_sel_i has a 1 at the region index and window_sel_i has a 1 at the window index. cs0_no is 0 on the cycle after each cycle in which a hit is sampled, and 1 otherwise. The default selectors 8'h80 and 8'h01 map the port to bytes 0xE000 to 0xE3FF.
- R3: read_no goes to 0 only for a hit with dbin_i at 1 and split bit 3 of the word address (byte offset 0x10) at 0. It goes low READ_DELAY cycles after such a request is first sampled, and stays low while the request holds.
- R4: read_no never falls unless cs0_no was already 0 on the previous cycle.
- R5: write_no is 0 on the cycle after a hit is sampled with we_ni at 0 and split bit 3 at 1.
- R6: A read phase followed by a write phase at a write alias never drives read_no low. A write at a read alias never drives write_no low.
- R7: An access that misses the window, or any cycle with memen_ni at 1, leaves all three strobes at 1 on the next cycle.
- R8: reg_sel_o always equals word address bits 2:0, with no delay.
- R9: led_on_o is the inverse of dasp_ni, with no delay.
- R10: A selector with no bits set never produces a hit. A region selector with several bits set maps the port into each selected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | Word address, bit 14 most significant |
| memen_ni | input | 1 | Memory cycle enable, active low |
| dbin_i | input | 1 | Read qualifier, high during a read |
| we_ni | input | 1 | Write enable, active low |
| region_sel_i | input | 8 | One-hot 8 KB region choice |
| window_sel_i | input | 8 | One-hot 1 KB window choice |
| dasp_ni | input | 1 | Drive activity, active low |
| cs0_no | output | 1 | Drive chip select, active low |
| read_no | output | 1 | Drive read strobe, active low |
| write_no | output | 1 | Drive write strobe, active low |
| reg_sel_o | output | 3 | Drive register select |
| led_on_o | output | 1 | Activity indicator, high when lit |

## Verification
Several properties are checked on every cycle: both strobes assert only under an active chip select, a read strobe falls only after the chip select was already low, and each strobe traces back to a request with the matching split-bit value and qualifier on the cycle before. The bench sweeps every region and window index, both aliases and both directions, so that the decode mapping, the exact read delay and the release after each cycle can be seen. Only the scenarios show the read-before-write sequence at the write alias, empty and multi-bit selectors, and the combinational pass-through pins.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  // Registered strobe state, active high internally
  typedef struct packed {
    logic cs;
    logic wr;
  } ide_strobe_t;

  localparam ide_strobe_t STROBE_IDLE = '{cs: 1'b0, wr: 1'b0};

  // Lowest address bit of a field that sits directly above `below` bits
  function automatic int field_lsb(input int below);
    return below;
  endfunction

endpackage

// File: rtl/ide_addr_match.sv
module ide_addr_match #(
  parameter int REGION_BITS = 3,
  parameter int WINDOW_BITS = 3,
  localparam int REGIONS = 1 << REGION_BITS,
  localparam int WINDOWS = 1 << WINDOW_BITS
) (
  input  logic [REGION_BITS-1:0] region_idx_i,
  input  logic [WINDOW_BITS-1:0] window_idx_i,
  input  logic                   memen_ni,
  input  logic [REGIONS-1:0]     region_sel_i,
  input  logic [WINDOWS-1:0]     window_sel_i,
  output logic                   hit_o
);

  logic [REGIONS-1:0] region_hit;
  logic [WINDOWS-1:0] window_hit;

  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    assign region_hit[r] = region_sel_i[r] && (region_idx_i == REGION_BITS'(r));
  end

  for (genvar w = 0; w < WINDOWS; w++) begin : g_window
    assign window_hit[w] = window_sel_i[w] && (window_idx_i == WINDOW_BITS'(w));
  end

  assign hit_o = !memen_ni && (|region_hit) && (|window_hit);

endmodule

// File: rtl/ide_rd_delay.sv
module ide_rd_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic hold_o
);

  logic [DEPTH-1:0] pipe_q;

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= req_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[DEPTH-2:0], req_i};
    end
  end

  // Asserted only once the request has held for DEPTH samples in a row
  assign hold_o = &pipe_q;

endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int REGION_BITS = 3,
  parameter int WINDOW_BITS = 3,
  parameter int REG_BITS    = 3,
  parameter int READ_DELAY  = 2,
  localparam int REGIONS    = 1 << REGION_BITS,
  localparam int WINDOWS    = 1 << WINDOW_BITS,
  localparam int SPLIT_BIT  = field_lsb(REG_BITS),
  localparam int WIN_LSB    = ADDR_W - REGION_BITS - WINDOW_BITS,
  localparam int REG_LSB    = ADDR_W - REGION_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                memen_ni,
  input  logic                dbin_i,
  input  logic                we_ni,
  input  logic [REGIONS-1:0]  region_sel_i,
  input  logic [WINDOWS-1:0]  window_sel_i,
  input  logic                dasp_ni,
  output logic                cs0_no,
  output logic                read_no,
  output logic                write_no,
  output logic [REG_BITS-1:0] reg_sel_o,
  output logic                led_on_o
);

  logic        hit;
  logic        split;
  logic        rd_req;
  logic        wr_req;
  logic        rd_ok;
  ide_strobe_t strb_q;
  logic        unused_mid_bits;

  assign unused_mid_bits = ^addr_i[WIN_LSB-1:SPLIT_BIT+1];

  ide_addr_match #(
    .REGION_BITS(REGION_BITS),
    .WINDOW_BITS(WINDOW_BITS)
  ) u_match (
    .region_idx_i (addr_i[ADDR_W-1:REG_LSB]),
    .window_idx_i (addr_i[REG_LSB-1:WIN_LSB]),
    .memen_ni     (memen_ni),
    .region_sel_i (region_sel_i),
    .window_sel_i (window_sel_i),
    .hit_o        (hit)
  );

  // Split bit picks the alias: 0 = read alias, 1 = write alias
  assign split  = addr_i[SPLIT_BIT];
  assign rd_req = hit && dbin_i && !split;
  assign wr_req = hit && !we_ni && split;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= STROBE_IDLE;
    else         strb_q <= '{cs: hit, wr: wr_req};
  end

  ide_rd_delay #(.DEPTH(READ_DELAY)) u_rd_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rd_req),
    .hold_o (rd_ok)
  );

  assign cs0_no    = !strb_q.cs;
  assign read_no   = !(strb_q.cs && rd_ok);
  assign write_no  = !(strb_q.cs && strb_q.wr);
  assign reg_sel_o = addr_i[REG_BITS-1:0];
  assign led_on_o  = !dasp_ni;

  // R4: read strobe falls only after chip select was already active
  a_r4_read_after_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(read_no) |-> $past(!cs0_no));

  // R3: read strobe implies chip select
  a_r3_read_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_no |-> !cs0_no);

  // R5: write strobe implies chip select
  a_r5_write_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_no |-> !cs0_no);

  // R6: a read strobe traces back to a read-alias request
  a_r6_read_alias_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_no |-> $past(dbin_i && !addr_i[SPLIT_BIT]));

  // R6: a write strobe traces back to a write-alias request
  a_r6_write_alias_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_no |-> $past(!we_ni && addr_i[SPLIT_BIT]));

  // R7: no memory cycle means no chip select next cycle
  a_r7_idle_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    memen_ni |=> cs0_no);

endmodule

// File: tb/ide_port_decoder_tb_top.sv
module ide_port_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RD_DLY     = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        memen_n = 1'b1;
  logic        dbin = 1'b0;
  logic        we_n = 1'b1;
  logic [7:0]  rsel = 8'h80;
  logic [7:0]  wsel = 8'h01;
  logic        dasp_n = 1'b1;
  logic        cs0_n, rd_n, wr_n, led;
  logic [2:0]  rs;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_port_decoder #(.READ_DELAY(RD_DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .memen_ni(memen_n),
    .dbin_i(dbin), .we_ni(we_n), .region_sel_i(rsel), .window_sel_i(wsel),
    .dasp_ni(dasp_n), .cs0_no(cs0_n), .read_no(rd_n), .write_no(wr_n),
    .reg_sel_o(rs), .led_on_o(led)
  );

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [14:0] mk(input int reg_i, input int win, input int mid,
                                     input int sp, input int rsb);
    return 15'((reg_i << 12) | (win << 9) | (mid << 4) | (sp << 3) | rsb);
  endfunction

  // Goes idle, then checks all strobes released (R7)
  task automatic go_idle(input string req);
    memen_n = 1'b1; dbin = 1'b0; we_n = 1'b1;
    @(negedge clk);
    chk(req, {cs0_n, rd_n, wr_n}, 3'b111);
  endtask

  // kind: 0 read, 1 write; holds 4 cycles, expected strobes from R2/R3/R5
  task automatic bus_cycle(input logic [14:0] a, input int kind, input logic men,
                           input string req);
    logic hit;
    logic sp;
    hit = men && rsel[a[14:12]] && wsel[a[11:9]];
    sp  = a[3];
    addr = a; memen_n = !men; dbin = (kind == 0); we_n = (kind != 1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk({req, " R2 cs"}, {cs0_n, 2'b00}, {!hit, 2'b00});
      chk({req, " R3 rd"}, {rd_n, 2'b00},
          {!(hit && kind == 0 && !sp && k >= RD_DLY), 2'b00});
      chk({req, " R5 wr"}, {wr_n, 2'b00}, {!(hit && kind == 1 && sp), 2'b00});
      chk("R8 reg_sel", rs, a[2:0]);
    end
    go_idle({req, " R7 release"});
  endtask

  // Read phase then write phase at the same address (R6)
  task automatic rmw(input logic [14:0] a, input string req);
    logic sp;
    sp = a[3];
    addr = a; memen_n = 1'b0; dbin = 1'b1; we_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk({req, " R6 rd phase"}, {cs0_n, rd_n, wr_n},
          {1'b0, !(!sp && k >= RD_DLY), 1'b1});
    end
    dbin = 1'b0; we_n = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk({req, " R6 wr phase"}, {cs0_n, rd_n, wr_n}, {1'b0, 1'b1, !sp});
    end
    go_idle({req, " R7 release"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    chk("R1 in reset", {cs0_n, rd_n, wr_n}, 3'b111);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {cs0_n, rd_n, wr_n}, 3'b111);

    // R2/R3/R5/R7: full sweep of regions, windows, aliases, directions
    for (int r = 0; r < 8; r++)
      for (int w = 0; w < 8; w++)
        for (int sp = 0; sp < 2; sp++)
          for (int kd = 0; kd < 2; kd++)
            bus_cycle(mk(r, w, (r + w) % 32, sp, (r * 3 + w) % 8), kd, 1'b1, "sweep");

    // R2: edges of default byte range 0xE000..0xE3FF
    bus_cycle(15'(16'hE000 >> 1), 0, 1'b1, "R2 low edge");
    bus_cycle(15'(16'hE3FE >> 1), 0, 1'b1, "R2 high edge");
    bus_cycle(15'(16'hE400 >> 1), 0, 1'b1, "R2 above");
    bus_cycle(15'(16'hDFFE >> 1), 0, 1'b1, "R2 below");

    // R7: hit address with memory enable inactive
    bus_cycle(mk(7, 0, 0, 0, 0), 0, 1'b0, "R7 memen off rd");
    bus_cycle(mk(7, 0, 0, 1, 0), 1, 1'b0, "R7 memen off wr");

    // R6: read-before-write at write alias and at read alias
    rmw(mk(7, 0, 1, 1, 5), "R6 write alias");
    rmw(mk(7, 0, 1, 0, 5), "R6 read alias");

    // R10: empty selector, then two regions selected
    rsel = 8'h00;
    bus_cycle(mk(7, 0, 0, 0, 1), 0, 1'b1, "R10 empty region");
    rsel = 8'h81; wsel = 8'h00;
    bus_cycle(mk(0, 0, 0, 1, 1), 1, 1'b1, "R10 empty window");
    wsel = 8'h10;
    for (int r = 0; r < 8; r++)
      bus_cycle(mk(r, 4, 2, 0, 6), 0, 1'b1, "R10 two regions");
    rsel = 8'h80; wsel = 8'h01;

    // R9: activity indicator pass-through
    dasp_n = 1'b0; #1;
    chk("R9 led on", {led, 2'b00}, 3'b100);
    dasp_n = 1'b1; #1;
    chk("R9 led off", {led, 2'b00}, 3'b000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule